// File: doc/BRIEF.md
# Color Palette Register Access Port

This block sits between a byte-wide host register bus and a 256-entry color lookup table. Each entry is a 24-bit color made of three 8-bit channels: red, green and blue. The host reaches the table through four byte registers. Two of them load a read pointer and a write pointer, and they cannot be read back. The third is a shared data register that moves one channel byte per access. The fourth is a compatibility control byte that has a single storage bit.

The block steps through the three channel bytes of an entry for the host. It advances the matching pointer only after the last byte of an entry has been moved. Reads and writes each have their own byte counter. A write sequence collects its first two bytes in holding registers and updates the table once, on the third byte. If the host loads the read pointer partway through a write sequence, that write sequence is dropped and the partial entry never reaches the table.

A separate scanout port looks up a pixel index and returns the registered 24-bit color one clock later. It runs in parallel with host access and never waits for it. The register path works the same way whatever the display mode is.

Top module: `pal_access_port`

## Requirements
- R1: After reset both pointers are 0, both byte counters point at red, and the control register (bus_sel = 3) reads 00h.
- R2: Three writes to the data register (bus_sel = 2) deliver red, green and blue in that order. The third write stores {red, green, blue} at the write pointer and then increments the write pointer.
- R3: The table entry does not change after only one or two data writes of a sequence.
- R4: Data register reads return red, then green, then blue of the entry at the read pointer. The read pointer increments after the blue byte is read.
- R5: Both pointers wrap from 255 to 0 when they auto-increment.
- R6: A write to the read pointer register (bus_sel = 0) loads the pointer and restarts the read byte counter at red. It also drops any unfinished write sequence, so that entry is not stored and the next data write is taken as red.
- R7: A write to the write pointer register (bus_sel = 1) loads the pointer and restarts the write sequence at red.
- R8: In the control register, bit 3 holds the last value written. Bits 7:4 and 2:0 always read 0.
- R9: Reads of the pointer registers (bus_sel = 0 or 1) return 00h and change no state.
- R10: scan_color is {red, green, blue}, with red in bits 23:16, of the entry at the scan_idx presented on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 2 | Register select: 0 read pointer, 1 write pointer, 2 data, 3 control |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, valid while bus_rd is high |
| scan_idx | input | 8 | Pixel palette index |
| scan_color | output | 24 | Registered color for the previous scan_idx |

## Verification
The checker assumes the host never raises bus_rd and bus_wr in the same cycle. It also assumes that a strobe is a plain one-cycle pulse held with a stable bus_sel. The bench drives every access through tasks that raise exactly one strobe for one cycle, so these assumptions always hold. Scanout checks are made in cycles with no bus write, so a lookup never lands on an entry that is being written at that same edge.

// File: rtl/pal_pkg.sv
// Package: shared register select encoding and field position for the
// palette access port. Assumes a 2-bit register select on the host bus.
package pal_pkg;
    typedef enum logic [1:0] {
        REG_RPTR = 2'd0,
        REG_WPTR = 2'd1,
        REG_DATA = 2'd2,
        REG_CTRL = 2'd3
    } pal_reg_e;

    localparam int CTRL_KEEP_BIT = 3;
endpackage

// File: rtl/pal_byte_seq.sv
// Module: byte position counter for one multi-byte entry transfer.
// Counts 0..N_STEP-1 on each step and wraps to 0 after the last position.
// Assumes clear and step are synchronous. Clear wins over step.
module pal_byte_seq #(
    parameter int N_STEP = 3,
    localparam int CW = (N_STEP > 1) ? $clog2(N_STEP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [CW-1:0] pos,
    output logic          at_last
);
    assign at_last = (pos == CW'(N_STEP - 1));

    // Advance, wrap or restart the byte position
    always_ff @(posedge clk) begin
        if (!rst_n)       pos <= '0;
        else if (clear)   pos <= '0;
        else if (step)    pos <= at_last ? '0 : pos + 1'b1;
    end
endmodule

// File: rtl/pal_index_reg.sv
// Module: palette pointer register with a direct load and an increment by one.
// Wraps naturally at 2**IDX_W. Assumes load and inc are not raised together.
// Load wins if they are.
module pal_index_reg #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             inc,
    output logic [IDX_W-1:0] idx
);
    // Load a new pointer or step the current one
    always_ff @(posedge clk) begin
        if (!rst_n)     idx <= '0;
        else if (load)  idx <= load_val;
        else if (inc)   idx <= idx + 1'b1;
    end
endmodule

// File: rtl/pal_ram.sv
// Module: palette storage with one write port, one unregistered host read
// port and one registered scanout read port. Assumes the contents are not
// reset. A scanout read of the entry written at the same edge returns the
// old value.
module pal_ram #(
    parameter int IDX_W  = 8,
    parameter int WORD_W = 24,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  haddr,
    output logic [WORD_W-1:0] hdata,
    input  logic [IDX_W-1:0]  saddr,
    output logic [WORD_W-1:0] sdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Store a complete entry
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Host side sees the current entry directly
    assign hdata = mem[haddr];

    // Scanout lookup with one cycle of latency
    always_ff @(posedge clk) begin
        if (!rst_n) sdata <= '0;
        else        sdata <= mem[saddr];
    end
endmodule

// File: rtl/pal_access_port.sv
// Module: host register front end for the color palette.
// Decodes read pointer, write pointer, data and control registers. Sequences
// channel bytes (red first) for both directions. Collects write bytes and
// stores the entry on the last one. Drops a partial write when the read
// pointer is loaded. Assumes bus_rd and bus_wr are one-cycle pulses and are
// never high together.
module pal_access_port #(
    parameter int IDX_W = 8,
    parameter int CH_W  = 8,
    parameter int N_CH  = 3,
    localparam int WORD_W = CH_W * N_CH,
    localparam int CW     = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [CH_W-1:0]   bus_wdata,
    output logic [CH_W-1:0]   bus_rdata,
    input  logic [IDX_W-1:0]  scan_idx,
    output logic [WORD_W-1:0] scan_color
);
    import pal_pkg::*;

    logic              ld_rptr, ld_wptr, data_wr, data_rd, ctrl_wr;
    logic [CW-1:0]     rd_pos, wr_pos;
    logic              rd_last, wr_last;
    logic [IDX_W-1:0]  rd_ptr, wr_ptr;
    logic [WORD_W-1:0] host_word, commit_word;
    logic [CH_W-1:0]   host_byte;
    logic [CH_W-1:0]   hold [N_CH-1];
    logic              ctrl_keep;
    logic              commit;

    // Register access decode
    assign ld_rptr = bus_wr && (bus_sel == REG_RPTR);
    assign ld_wptr = bus_wr && (bus_sel == REG_WPTR);
    assign data_wr = bus_wr && (bus_sel == REG_DATA);
    assign ctrl_wr = bus_wr && (bus_sel == REG_CTRL);
    assign data_rd = bus_rd && (bus_sel == REG_DATA);
    assign commit  = data_wr && wr_last;

    pal_byte_seq #(.N_STEP(N_CH)) u_rd_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ld_rptr),
        .step    (data_rd),
        .pos     (rd_pos),
        .at_last (rd_last)
    );

    pal_byte_seq #(.N_STEP(N_CH)) u_wr_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ld_rptr || ld_wptr),
        .step    (data_wr),
        .pos     (wr_pos),
        .at_last (wr_last)
    );

    pal_index_reg #(.IDX_W(IDX_W)) u_rd_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_rptr),
        .load_val (bus_wdata[IDX_W-1:0]),
        .inc      (data_rd && rd_last),
        .idx      (rd_ptr)
    );

    pal_index_reg #(.IDX_W(IDX_W)) u_wr_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_wptr),
        .load_val (bus_wdata[IDX_W-1:0]),
        .inc      (commit),
        .idx      (wr_ptr)
    );

    // One holding register for each channel except the last
    for (genvar c = 0; c < N_CH - 1; c++) begin : g_hold
        // Capture the channel byte at its sequence position
        always_ff @(posedge clk) begin
            if (!rst_n)                             hold[c] <= '0;
            else if (data_wr && wr_pos == CW'(c))   hold[c] <= bus_wdata;
        end
    end

    // Assemble the stored word with the first channel in the top byte
    always_comb begin
        commit_word = '0;
        for (int c = 0; c < N_CH - 1; c++)
            commit_word[(N_CH - 1 - c) * CH_W +: CH_W] = hold[c];
        commit_word[CH_W-1:0] = bus_wdata;
    end

    pal_ram #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .waddr (wr_ptr),
        .wdata (commit_word),
        .haddr (rd_ptr),
        .hdata (host_word),
        .saddr (scan_idx),
        .sdata (scan_color)
    );

    // Pick the channel byte at the read position
    always_comb begin
        host_byte = '0;
        for (int c = 0; c < N_CH; c++)
            if (rd_pos == CW'(c)) host_byte = host_word[(N_CH - 1 - c) * CH_W +: CH_W];
    end

    // Compatibility control bit storage
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_keep <= 1'b0;
        else if (ctrl_wr) ctrl_keep <= bus_wdata[CTRL_KEEP_BIT];
    end

    // Read data multiplexer; pointer registers read as zero
    always_comb begin
        bus_rdata = '0;
        case (bus_sel)
            REG_DATA: bus_rdata = host_byte;
            REG_CTRL: bus_rdata[CTRL_KEEP_BIT] = ctrl_keep;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pal_access_port_chk.sv
// Module: property checker for the palette access port, bound to the top.
// Assumes single-cycle strobes that are never high together.
module pal_access_port_chk #(
    parameter int IDX_W = 8,
    parameter int CH_W  = 8,
    parameter int N_CH  = 3,
    localparam int CW   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_sel,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [CH_W-1:0]  bus_rdata,
    input logic [CW-1:0]    rd_pos,
    input logic [CW-1:0]    wr_pos,
    input logic [IDX_W-1:0] rd_ptr,
    input logic [IDX_W-1:0] wr_ptr
);
    logic d_rd, d_wr;
    assign d_rd = bus_rd && (bus_sel == 2'd2);
    assign d_wr = bus_wr && (bus_sel == 2'd2);

    a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    a_r1_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pos < CW'(N_CH)) && (wr_pos < CW'(N_CH)));

    a_r4_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (d_rd && rd_pos == CW'(N_CH - 1)) |=>
        (rd_pos == '0) && (rd_ptr == IDX_W'($past(rd_ptr) + 1'b1)));

    a_r2_write_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (d_wr && wr_pos == CW'(N_CH - 1)) |=>
        (wr_pos == '0) && (wr_ptr == IDX_W'($past(wr_ptr) + 1'b1)));

    a_r3_partial_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (d_wr && wr_pos != CW'(N_CH - 1)) |=> $stable(wr_ptr));

    a_r6_rptr_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd0) |=> (rd_pos == '0) && (wr_pos == '0));

    a_r7_wptr_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd1) |=> (wr_pos == '0));

    a_r8_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 2'd3) |-> (bus_rdata[CH_W-1:4] == '0) && (bus_rdata[2:0] == '0));

    a_r9_ptr_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel[1] == 1'b0) |-> (bus_rdata == '0));

    a_r9_ptr_read_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel[1] == 1'b0) |=> $stable(rd_pos) && $stable(rd_ptr));
endmodule

bind pal_access_port pal_access_port_chk #(
    .IDX_W (IDX_W),
    .CH_W  (CH_W),
    .N_CH  (N_CH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .rd_pos    (rd_pos),
    .wr_pos    (wr_pos),
    .rd_ptr    (rd_ptr),
    .wr_ptr    (wr_ptr)
);

// File: tb/test_pal_access_port.sv
// Bench: directed corner cases followed by seeded random register traffic,
// compared against a bench-side palette model.
module test_pal_access_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_sel = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  scan_idx = '0;
    logic [23:0] scan_color;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model state
    logic [23:0] m_pal [256];
    logic [7:0]  m_rptr = '0, m_wptr = '0;
    int          m_rpos = 0, m_wpos = 0;
    logic [7:0]  m_hold [2];
    logic        m_keep = 1'b0;

    always #2 clk = ~clk;

    pal_access_port i_pal_access_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .scan_idx   (scan_idx),
        .scan_color (scan_color)
    );

    function automatic logic [7:0] chan(input logic [23:0] w, input int pos);
        return w[(2 - pos) * 8 +: 8];
    endfunction

    function automatic logic [7:0] ctrl_expect(input logic keep);
        return {4'h0, keep, 3'b000};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        case (sel)
            2'd0: begin m_rptr = d; m_rpos = 0; m_wpos = 0; end
            2'd1: begin m_wptr = d; m_wpos = 0; end
            2'd2: begin
                if (m_wpos < 2) begin m_hold[m_wpos] = d; m_wpos++; end
                else begin
                    m_pal[m_wptr] = {m_hold[0], m_hold[1], d};
                    m_wptr++; m_wpos = 0;
                end
            end
            default: m_keep = d[3];
        endcase
    endtask

    task automatic bus_read(input logic [1:0] sel, input string tag);
        logic [7:0] exp;
        @(negedge clk);
        bus_sel = sel; bus_rd = 1'b1;
        #1;
        case (sel)
            2'd2:    exp = chan(m_pal[m_rptr], m_rpos);
            2'd3:    exp = ctrl_expect(m_keep);
            default: exp = 8'h00;
        endcase
        check(tag, {24'h0, bus_rdata}, {24'h0, exp});
        @(negedge clk);
        bus_rd = 1'b0;
        if (sel == 2'd2) begin
            if (m_rpos == 2) begin m_rpos = 0; m_rptr++; end
            else m_rpos++;
        end
    endtask

    task automatic scan_check(input logic [7:0] idx, input string tag);
        @(negedge clk);
        scan_idx = idx;
        @(negedge clk);
        check(tag, {8'h0, scan_color}, {8'h0, m_pal[idx]});
    endtask

    task automatic write_entry(input logic [23:0] w);
        bus_write(2'd2, w[23:16]);
        bus_write(2'd2, w[15:8]);
        bus_write(2'd2, w[7:0]);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] old;
        void'($urandom(32'h1bad5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state; R9 pointer registers read zero
        bus_read(2'd3, "R1 control reset");
        bus_read(2'd0, "R9 read ptr reg");
        bus_read(2'd1, "R9 write ptr reg");

        // R2 and R5: fill the whole table from pointer 0 and let it wrap
        bus_write(2'd1, 8'd0);
        for (int i = 0; i < 256; i++) write_entry(24'($urandom));
        write_entry(24'hA1B2C3);
        bus_write(2'd0, 8'd0);
        bus_read(2'd2, "R5 write ptr wrap red");
        bus_read(2'd2, "R5 write ptr wrap green");
        bus_read(2'd2, "R5 write ptr wrap blue");

        // R4 and R5: read across the end of the table
        bus_write(2'd0, 8'd254);
        for (int i = 0; i < 9; i++) bus_read(2'd2, "R4 R5 read wrap");

        // R3 and R6: a partial write is dropped by a read pointer load
        bus_write(2'd1, 8'd10);
        old = m_pal[10];
        bus_write(2'd2, 8'h11);
        bus_write(2'd2, 8'h22);
        scan_check(8'd10, "R3 partial not stored");
        bus_write(2'd0, 8'd10);
        for (int i = 0; i < 3; i++) bus_read(2'd2, "R6 entry kept after abort");
        check("R6 entry unchanged", {8'h0, m_pal[10]}, {8'h0, old});
        write_entry(24'h445566);
        scan_check(8'd10, "R6 next write starts at red");

        // R6: a read pointer load restarts the read sequence
        bus_write(2'd0, 8'd20);
        bus_read(2'd2, "R6 first byte");
        bus_write(2'd0, 8'd30);
        bus_read(2'd2, "R6 restart at red");

        // R7: a write pointer load restarts the write sequence
        bus_write(2'd1, 8'd40);
        bus_write(2'd2, 8'h99);
        bus_write(2'd1, 8'd41);
        write_entry(24'h0F1E2D);
        scan_check(8'd40, "R7 old entry kept");
        scan_check(8'd41, "R7 new entry stored");

        // R8: control bit storage and reserved bits
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, "R8 all ones written");
        bus_write(2'd3, 8'hF7);
        bus_read(2'd3, "R8 bit3 clear");
        bus_write(2'd3, 8'h08);
        bus_read(2'd3, "R8 bit3 only");

        // R9: pointer register reads in the middle of a read sequence
        bus_write(2'd0, 8'd77);
        bus_read(2'd2, "R9 before");
        bus_read(2'd0, "R9 mid read ptr");
        bus_read(2'd1, "R9 mid write ptr");
        bus_read(2'd2, "R9 sequence kept");

        // R10: scanout of a few directed entries
        scan_check(8'd0, "R10 scan entry 0");
        scan_check(8'd255, "R10 scan entry 255");

        // Random mix of register traffic and scanout lookups
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = int'($urandom % 16);
            if (op < 1)       bus_write(2'd0, 8'($urandom));
            else if (op < 2)  bus_write(2'd1, 8'($urandom));
            else if (op < 7)  bus_write(2'd2, 8'($urandom));
            else if (op < 11) bus_read(2'd2, "R4 random data read");
            else if (op < 12) bus_write(2'd3, 8'($urandom));
            else if (op < 13) bus_read(2'd3, "R8 random control read");
            else if (op < 14) bus_read(2'($urandom % 2), "R9 random ptr read");
            else              scan_check(8'($urandom), "R10 random scan");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule